// File: doc/BRIEF.md
# PS/2 Device Transmit Engine

This block is the device-to-host half of a PS/2 device controller. Software fills a small buffer of four 32-bit words and sets a byte count. The engine then sends the bytes one at a time as PS/2 frames on the bus. Because the device owns the PS/2 clock, the engine generates that clock itself. A half-period tick from elsewhere in the chip paces it. The tick is normally set so the bus clock lands between about 10 and 16.7 kHz.

Both bus lines are open-drain. The engine only pulls a line low or releases it, and it reads the resolved line levels back through a synchronizer. Before it starts a frame it waits until both lines are seen high. If the host holds the clock low during a frame, the engine drops that frame and keeps its byte position, so the same byte is sent again once the bus is free. A clear command stops the transfer at any point but leaves the stored words untouched. The engine reports a busy flag, an empty flag, the current byte index and a latched completion flag with a maskable interrupt.

Top module: `ps2_dev_tx`

## Requirements
- R1: Every frame is 11 bits. It is a start bit of 0, then the eight data bits least significant first, then an odd parity bit (data plus parity holds an odd number of ones), then a stop bit of 1. The data line changes only while the engine has the clock released, and each bit is valid at the falling clock edge.
- R2: The 4-bit byte index picks the byte to send. Index bits [3:2] select data word 0 to 3 and bits [1:0] select the lane, with lane 0 = bits [7:0] up to lane 3 = bits [31:24]. Bytes go out in index order starting from 0.
- R3: A depth value of N sends N+1 bytes, so values 0 to 15 give 1 to 16 bytes. After the byte at index N completes, the empty flag is 1 and the byte index is 0.
- R4: A word write while the enable input is 1 clears the empty flag on the next cycle. A word write while the enable input is 0 stores the word but leaves the empty flag at 1, and no frame is sent.
- R5: A frame starts only at a tick where both synchronized lines are high. While the host holds data low, the engine stays not busy with the empty flag at 0, and it starts once the line is released.
- R6: A clear pulse, on the next cycle, ends any frame, releases both lines, sets the empty flag and sets the byte index to 0. Stored words are not altered.
- R7: If the host holds the clock low while the engine has it released mid-frame, the engine aborts at the next tick. It becomes not busy with the byte index unchanged and later sends that byte again in full.
- R8: The completion flag is set after each stop bit and is cleared by a clear-flag pulse. The interrupt output equals the flag ANDed with the interrupt-enable input.
- R9: Busy is 1 from the start of a frame until it completes or aborts. Whenever busy is 0, both line pull-down enables are 0.
- R10: After reset: busy 0, empty 1, byte index 0, completion flag 0, interrupt 0, both pull-down enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per PS/2 clock half-period |
| en_i | input | 1 | Controller enable |
| depth_i | input | 4 | Bytes to send minus one |
| wr_en_i | input | 1 | Data word write strobe |
| wr_sel_i | input | 2 | Data word number 0..3 |
| wr_data_i | input | 32 | Data word value |
| clear_i | input | 1 | Abort transfer, mark buffer empty |
| txint_en_i | input | 1 | Interrupt enable |
| txint_clr_i | input | 1 | Clear the completion flag |
| kclk_i | input | 1 | Resolved PS/2 clock line level |
| kdat_i | input | 1 | Resolved PS/2 data line level |
| kclk_oe_o | output | 1 | Pull clock line low |
| kdat_oe_o | output | 1 | Pull data line low |
| busy_o | output | 1 | Frame in progress |
| empty_o | output | 1 | Nothing left to send |
| byte_idx_o | output | 4 | Index of current byte |
| txint_o | output | 1 | Completion flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest case to reach is a host clock inhibit that lands inside a frame, in the middle of a multi-byte transfer. The engine has to drop the partial frame, keep the byte index where it was, and later resend that byte with no gap or duplicate in the sequence the host sees. The bench waits until the byte index shows the second byte and busy is high. It then waits a few bit times and holds the clock line low from the host side. While the hold lasts, its host receiver throws away the partial frame. It then checks that the four completed frames carry bytes 0 to 3 in order. A clear issued in the middle of a 16-byte run, followed by a rewrite of one word only, shows through the bytes that come out that the other words were kept.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;
  localparam int FRAME_BITS = 11;
  localparam int BITN_W     = $clog2(FRAME_BITS);
  localparam int BYTE_W     = 8;

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [BYTE_W-1:0] b);
    return {1'b1, ~^b, b, 1'b0};
  endfunction
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= '1;
      else if (g == 0) st[g] <= d_i;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/ps2_tx_buf.sv
module ps2_tx_buf #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  localparam int LANES  = WORD_W / 8,
  localparam int SEL_W  = $clog2(WORDS),
  localparam int LANE_W = $clog2(LANES),
  localparam int IDX_W  = SEL_W + LANE_W
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [7:0]        byte_o
);
  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] word;
  logic [7:0]        lane_b [LANES];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_sel_i] <= wr_data_i;
  end

  assign word = mem[idx_i[IDX_W-1:LANE_W]];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_b[g] = word[g*8 +: 8];
  end

  assign byte_o = lane_b[idx_i[LANE_W-1:0]];
endmodule

// File: rtl/ps2_tx_frame.sv
module ps2_tx_frame
  import ps2_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              clk_sense_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              clk_oe_o,
  output logic              dat_oe_o
);
  localparam logic [BITN_W-1:0] LAST = BITN_W'(FRAME_BITS-1);

  logic                  busy_q, low_q, done_q, clk_oe_q, dat_oe_q;
  logic [BITN_W-1:0]     bitn_q;
  logic [FRAME_BITS-1:0] shr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      low_q    <= 1'b0;
      done_q   <= 1'b0;
      clk_oe_q <= 1'b0;
      dat_oe_q <= 1'b0;
      bitn_q   <= '0;
      shr_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q   <= 1'b0;
        low_q    <= 1'b0;
        clk_oe_q <= 1'b0;
        dat_oe_q <= 1'b0;
      end else if (!busy_q) begin
        if (start_i) begin
          busy_q   <= 1'b1;
          low_q    <= 1'b0;
          bitn_q   <= '0;
          shr_q    <= build_frame(byte_i);
          dat_oe_q <= 1'b1;
          clk_oe_q <= 1'b0;
        end
      end else if (tick_i) begin
        if (!low_q) begin
          if (!clk_sense_i) begin
            busy_q   <= 1'b0;
            clk_oe_q <= 1'b0;
            dat_oe_q <= 1'b0;
          end else begin
            low_q    <= 1'b1;
            clk_oe_q <= 1'b1;
          end
        end else begin
          low_q    <= 1'b0;
          clk_oe_q <= 1'b0;
          if (bitn_q == LAST) begin
            busy_q   <= 1'b0;
            dat_oe_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bitn_q   <= bitn_q + 1'b1;
            shr_q    <= {1'b1, shr_q[FRAME_BITS-1:1]};
            dat_oe_q <= ~shr_q[1];
          end
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign clk_oe_o = clk_oe_q;
  assign dat_oe_o = dat_oe_q;

  // R9
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!clk_oe_q && !dat_oe_q));
  // R1
  clk_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !abort_i) |=> $stable(clk_oe_q));
  // R1
  data_while_high_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dat_oe_q) |-> !clk_oe_q);
endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx #(
  parameter int WORDS       = 4,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LANES = WORD_W / 8,
  localparam int SEL_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(WORDS * LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  depth_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              clear_i,
  input  logic              txint_en_i,
  input  logic              txint_clr_i,
  input  logic              kclk_i,
  input  logic              kdat_i,
  output logic              kclk_oe_o,
  output logic              kdat_oe_o,
  output logic              busy_o,
  output logic              empty_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic              txint_o,
  output logic              irq_o
);
  logic [1:0]       sync_q;
  logic             clk_s, dat_s, busy, done, start, txint_d;
  logic             empty_q, txint_q, irq_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       cur_byte;

  ps2_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
    .clk(clk), .rst(rst), .d_i({kclk_i, kdat_i}), .q_o(sync_q));
  assign clk_s = sync_q[1];
  assign dat_s = sync_q[0];

  ps2_tx_buf #(.WORDS(WORDS), .WORD_W(WORD_W)) buf_i (
    .clk(clk), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .idx_i(idx_q), .byte_o(cur_byte));

  assign start = tick_i && en_i && !empty_q && clk_s && dat_s && !clear_i;

  ps2_tx_frame frame_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(start), .abort_i(clear_i),
    .byte_i(cur_byte), .clk_sense_i(clk_s), .busy_o(busy), .done_o(done),
    .clk_oe_o(kclk_oe_o), .dat_oe_o(kdat_oe_o));

  assign txint_d = done ? 1'b1 : (txint_clr_i ? 1'b0 : txint_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      idx_q   <= '0;
      txint_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      txint_q <= txint_d;
      irq_q   <= txint_d && txint_en_i;
      if (clear_i) begin
        empty_q <= 1'b1;
        idx_q   <= '0;
      end else begin
        if (done) begin
          if (idx_q >= depth_i) begin
            idx_q   <= '0;
            empty_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        if (wr_en_i && en_i) empty_q <= 1'b0;
      end
    end
  end

  assign busy_o     = busy;
  assign empty_o    = empty_q;
  assign byte_idx_o = idx_q;
  assign txint_o    = txint_q;
  assign irq_o      = irq_q;

  // R3
  empty_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    empty_q |-> (idx_q == '0));
  // R6
  clear_abort_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (empty_q && idx_q == '0 && !busy && !kclk_oe_o && !kdat_oe_o));
  // R8
  txint_set_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> txint_q);
  // R4
  wr_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && en_i && !clear_i) |=> !empty_q);
endmodule

// File: tb/ps2_dev_tx_tb.sv
module ps2_dev_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 10;

  typedef struct packed {
    logic [3:0]  depth;
    logic [31:0] w3, w2, w1, w0;
  } vec_t;

  localparam vec_t VECS [0:3] = '{
    '{4'd0,  32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h1234_56A5},
    '{4'd3,  32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFF00_7F80},
    '{4'd6,  32'h0000_0000, 32'h0000_0000, 32'h0BAD_F00D, 32'hC3E1_0001},
    '{4'd15, 32'hFEDC_BA98, 32'h7654_3210, 32'h0F1E_2D3C, 32'h4B5A_6978}
  };

  logic clk = 0, rst = 1, tick = 0, en = 0, wr_en = 0, clear = 0;
  logic txint_en = 0, txint_clr = 0, host_clk_pull = 0, host_dat_pull = 0;
  logic [3:0]  depth = 0;
  logic [1:0]  wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic kclk_oe, kdat_oe, busy, empty, txint, irq;
  logic [3:0] bidx;
  logic kclk_line, kdat_line;

  assign kclk_line = !(kclk_oe || host_clk_pull);
  assign kdat_line = !(kdat_oe || host_dat_pull);

  ps2_dev_tx dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .en_i(en), .depth_i(depth),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .clear_i(clear),
    .txint_en_i(txint_en), .txint_clr_i(txint_clr), .kclk_i(kclk_line),
    .kdat_i(kdat_line), .kclk_oe_o(kclk_oe), .kdat_oe_o(kdat_oe),
    .busy_o(busy), .empty_o(empty), .byte_idx_o(bidx), .txint_o(txint), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tick_cnt = 0;
  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
    tick     <= (tick_cnt == TICK_DIV-1);
  end

  // host-side receiver: samples data at each falling clock edge it did not cause
  logic        rx_clr = 0;
  logic        prev_clk = 1;
  logic [10:0] rx_sh;
  int          rx_n = 0, rx_cnt = 0, frame_bad = 0;
  logic [7:0]  rx_b [0:31];
  always @(posedge clk) begin
    if (rx_clr) begin
      rx_cnt = 0; frame_bad = 0; rx_n = 0;
    end else if (host_clk_pull || clear) begin
      rx_n = 0;
    end else if (prev_clk && !kclk_line) begin
      rx_sh[rx_n] = kdat_line;
      rx_n = rx_n + 1;
      if (rx_n == 11) begin
        if (rx_sh[0] != 1'b0 || rx_sh[10] != 1'b1 || (^rx_sh[9:1]) != 1'b1)
          frame_bad = frame_bad + 1;
        if (rx_cnt < 32) rx_b[rx_cnt] = rx_sh[8:1];
        rx_cnt = rx_cnt + 1;
        rx_n = 0;
      end
    end
    prev_clk = kclk_line;
  end

  int checks = 0, errors = 0, cycles = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_word(input logic [1:0] s, input logic [31:0] d);
    wr_sel = s; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_clear_rx();
    rx_clr = 1; @(negedge clk); rx_clr = 0;
  endtask

  task automatic wait_empty(input string tag);
    int n = 0;
    while (!(empty && !busy) && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, tag, n, 0);
    cyc(3);
  endtask

  function automatic logic [7:0] exp_byte(input vec_t v, input int k);
    logic [31:0] w;
    case (k / 4)
      0: w = v.w0; 1: w = v.w1; 2: w = v.w2; default: w = v.w3;
    endcase
    return w[8*(k%4) +: 8];
  endfunction

  task automatic check_bytes(input vec_t v, input int n, input string tag);
    int bad = 0;
    chk(rx_cnt == n, {tag, " frame count"}, rx_cnt, n);
    for (int k = 0; k < n && k < 32; k++)
      if (rx_b[k] != exp_byte(v, k)) bad++;
    chk(bad == 0, {tag, " byte order"}, bad, 0);
    chk(frame_bad == 0, "R1 frame format", frame_bad, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    int idx_hold;
    cyc(4);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(!busy && empty && bidx == 0 && !txint && !irq && !kclk_oe && !kdat_oe,
        "R10 reset state", {busy, empty, bidx, txint, irq}, 6'b010000);

    en = 1; txint_en = 1;
    // table walk: R2, R3, R8
    for (int i = 0; i < 4; i++) begin
      v = VECS[i];
      pulse_clear_rx();
      depth = v.depth;
      write_word(0, v.w0); write_word(1, v.w1);
      write_word(2, v.w2); write_word(3, v.w3);
      wait_empty("R3 transfer completes");
      check_bytes(v, int'(v.depth) + 1, "R2 R3");
      chk(empty && bidx == 0, "R3 empty and index after depth", bidx, 0);
      chk(txint && irq, "R8 flag and interrupt after stop", {txint, irq}, 2'b11);
      txint_clr = 1; @(negedge clk); txint_clr = 0; @(negedge clk);
      chk(!txint && !irq, "R8 flag cleared", {txint, irq}, 0);
    end

    // R4: write while disabled stores but does not send
    pulse_clear_rx();
    en = 0; depth = 0;
    write_word(0, 32'h0000_005C);
    chk(empty, "R4 empty held while disabled", empty, 1);
    cyc(300);
    chk(!busy && rx_cnt == 0, "R4 nothing sent while disabled", rx_cnt, 0);
    en = 1;
    write_word(1, 32'h1111_1111);
    chk(!empty, "R4 write clears empty next cycle", empty, 0);
    wait_empty("R4 transfer");
    chk(rx_cnt == 1 && rx_b[0] == 8'h5C, "R4 stored word sent", rx_b[0], 8'h5C);

    // R5: data held low by host blocks the start
    pulse_clear_rx();
    host_dat_pull = 1;
    write_word(0, 32'h0000_00E7);
    cyc(120);
    chk(!busy && !empty && !kclk_oe, "R5 waits for idle bus", {busy, empty}, 2'b00);
    host_dat_pull = 0;
    cyc(25);
    chk(busy, "R9 busy after start", busy, 1);
    wait_empty("R5 transfer");
    chk(rx_cnt == 1 && rx_b[0] == 8'hE7, "R5 sent after release", rx_b[0], 8'hE7);

    // R6: clear mid-transfer, buffer retained
    txint_en = 0;
    v = '{4'd15, 32'h3333_3333, 32'h2222_2222, 32'hCAFE_BABE, 32'h8421_1248};
    pulse_clear_rx();
    depth = 15;
    write_word(0, v.w0); write_word(1, v.w1);
    write_word(2, v.w2); write_word(3, v.w3);
    while (bidx != 2) @(negedge clk);
    cyc(70);
    clear = 1; @(negedge clk); clear = 0;
    chk(empty && bidx == 0 && !busy && !kclk_oe && !kdat_oe,
        "R6 clear aborts", {empty, bidx, busy}, 6'b100000);
    chk(txint && !irq, "R8 interrupt masked", {txint, irq}, 2'b10);
    cyc(100);
    chk(!busy, "R6 stays stopped", busy, 0);
    pulse_clear_rx();
    depth = 7;
    v.w1 = 32'h55AA_0FF0;
    write_word(1, v.w1);
    wait_empty("R6 restart");
    check_bytes(v, 8, "R6 buffer kept");

    // R7: host clock inhibit mid-frame
    v = '{4'd3, 32'h0, 32'h0, 32'h0, 32'h9D3C_6E01};
    pulse_clear_rx();
    depth = 3;
    write_word(0, v.w0);
    while (!(bidx == 1 && busy)) @(negedge clk);
    cyc(45);
    idx_hold = int'(bidx);
    host_clk_pull = 1;
    cyc(30);
    chk(!busy && int'(bidx) == idx_hold, "R7 abort keeps index", bidx, idx_hold);
    chk(!kclk_oe && !kdat_oe, "R9 lines released after abort", {kclk_oe, kdat_oe}, 0);
    cyc(70);
    host_clk_pull = 0;
    wait_empty("R7 transfer");
    check_bytes(v, 4, "R7 resend");

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule